// File: doc/BRIEF.md
# Frequency Counter Gate Controller

This block runs one gated frequency measurement. A decimal time base, a chain of BCD decades driven by the system clock, divides the reference down to a gate period that can be selected. A toggle register opens the measurement gate on one time-base rollover and closes it on the next. While the gate is open, rising edges of the measured signal are counted in a BCD counter chain. The measured signal is first brought into the clock domain by two flip-flops and then passed through an edge detector. If the counter wraps past its largest value, an overflow flag is set and held.

Every measurement begins with a reset. Reset zeroes the count, the overflow flag and the gate, and loads every time-base decade with nine. As a result, the first clock after reset rolls the whole time base over and opens the gate at a clean decade boundary. When the gate closes, a done pulse is issued. The result then stays frozen until the next reset.

Top module: `freq_gate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `count_bcd` becomes 0 and `overflow`, `gate_active` and `meas_done` become 0 at that edge.
- R2: Reset loads every time-base decade with 9, so `gate_active` is 1 after the first clock edge at which `rst` is low.
- R3: `gate_active` stays high for exactly 10^(s+1) clock cycles, where s is the latched gate select (0 gives 10 cycles, 3 gives 10000 cycles with four time-base decades).
- R4: `gate_sel` is captured only while `rst` is high; changes to it during a measurement have no effect on the gate length.
- R5: `sig_in` passes through two synchronizing flip-flops and an edge detector. A low-to-high change of `sig_in` sampled at edge k is counted at edge k+2, provided `gate_active` is 1 before that edge.
- R6: `count_bcd` is packed BCD: 4 bits per digit, digit 0 (units) in bits [3:0], every digit within 0 to 9.
- R7: When a counted edge arrives while every count digit is 9, the count wraps to 0 and `overflow` becomes 1. It then stays 1 until reset.
- R8: `meas_done` is high for exactly one cycle, at the same edge where `gate_active` falls. After that the gate never reopens, and `count_bcd` and `overflow` hold until reset.
- R9: Rising edges of `sig_in` that arrive while the gate is closed, before it opens or after it has closed, do not change `count_bcd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and system clock |
| rst | input | 1 | Synchronous active-high measurement reset |
| sig_in | input | 1 | Measured signal, asynchronous |
| gate_sel | input | $clog2(TB_DIGITS) | Gate-time select; number of time-base decades used minus one |
| count_bcd | output | 4*CNT_DIGITS | Packed BCD event count |
| overflow | output | 1 | Sticky count wrap flag |
| gate_active | output | 1 | Measurement gate open |
| meas_done | output | 1 | One-cycle pulse when the gate closes |

## Verification
The closing time-base tick and a counted input edge can land in the same clock cycle. The gate register is still high at that edge, so the edge must be counted, and any edge one cycle later must not be. The bench toggles `sig_in` every cycle so that an edge falls on every other cycle, and it also uses random and sparse patterns, so both parities of the closing cycle occur. A behavioural reference model is compared against the count, gate, overflow and done outputs on every clock. A counter that is too small for a 10000-cycle gate forces the overflow wrap to happen while the gate is open, and the bench then checks that the flag stays set.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;

  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == BCD_MAX) ? 4'd0 : d + 4'd1;
  endfunction
endpackage

// File: rtl/fgc_bcd_chain.sv
module fgc_bcd_chain
  import fgc_pkg::*;
#(
  parameter int DIGITS     = 4,
  parameter bit PRESET_MAX = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  output logic [DIGITS*4-1:0] value,
  output logic [DIGITS-1:0]   low_max,
  output logic                carry_o
);
  localparam bcd_t RST_VAL = PRESET_MAX ? BCD_MAX : 4'd0;

  bcd_t              dig [DIGITS];
  logic [DIGITS-1:0] is_max;

  always_comb begin
    low_max[0] = is_max[0];
    for (int k = 1; k < DIGITS; k++) low_max[k] = low_max[k-1] & is_max[k];
  end

  assign carry_o = inc && low_max[DIGITS-1];

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic step;
    if (i == 0) begin : g_lsd
      assign step = inc;
    end else begin : g_upper
      assign step = inc && low_max[i-1];
    end
    assign is_max[i]         = (dig[i] == BCD_MAX);
    assign value[i*4 +: 4]   = dig[i];

    always_ff @(posedge clk) begin
      if (rst)       dig[i] <= RST_VAL;
      else if (step) dig[i] <= bcd_step(dig[i]);
    end

    // R6
    digit_range_chk: assert property (@(posedge clk) disable iff (rst) dig[i] <= BCD_MAX);
  end
endmodule

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/fgc_gate_ctrl.sv
module fgc_gate_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic gate_o,
  output logic done_o,
  output logic closed_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o   <= 1'b0;
      done_o   <= 1'b0;
      closed_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick && !closed_o) begin
        if (!gate_o) begin
          gate_o <= 1'b1;
        end else begin
          gate_o   <= 1'b0;
          closed_o <= 1'b1;
          done_o   <= 1'b1;
        end
      end
    end
  end

  // R8
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!gate_o && $past(gate_o)));
  // R8
  no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    closed_o |=> !gate_o);
endmodule

// File: rtl/freq_gate_ctrl.sv
module freq_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int TB_DIGITS  = 4,
  parameter int CNT_DIGITS = 4,
  localparam int SEL_W     = (TB_DIGITS > 1) ? $clog2(TB_DIGITS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sig_in,
  input  logic [SEL_W-1:0]        gate_sel,
  output logic [CNT_DIGITS*4-1:0] count_bcd,
  output logic                    overflow,
  output logic                    gate_active,
  output logic                    meas_done
);
  logic [SEL_W-1:0]        sel_q;
  logic [TB_DIGITS*4-1:0]  tb_digits;
  logic [TB_DIGITS-1:0]    tb_low;
  logic                    tb_carry;
  logic [CNT_DIGITS-1:0]   cnt_low;
  logic                    cnt_carry;
  logic                    closed;
  logic                    tick;
  logic                    rise;
  logic                    cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (int'(gate_sel) >= TB_DIGITS) sel_q <= SEL_W'(TB_DIGITS - 1);
      else                             sel_q <= gate_sel;
    end
  end

  assign tick    = !closed && tb_low[sel_q];
  assign cnt_inc = rise && gate_active;

  fgc_bcd_chain #(.DIGITS(TB_DIGITS), .PRESET_MAX(1'b1)) u_timebase (
    .clk(clk), .rst(rst), .inc(!closed),
    .value(tb_digits), .low_max(tb_low), .carry_o(tb_carry)
  );

  fgc_gate_ctrl u_gate (
    .clk(clk), .rst(rst), .tick(tick),
    .gate_o(gate_active), .done_o(meas_done), .closed_o(closed)
  );

  fgc_edge_sync u_sync (
    .clk(clk), .rst(rst), .din(sig_in), .rise(rise)
  );

  fgc_bcd_chain #(.DIGITS(CNT_DIGITS), .PRESET_MAX(1'b0)) u_count (
    .clk(clk), .rst(rst), .inc(cnt_inc),
    .value(count_bcd), .low_max(cnt_low), .carry_o(cnt_carry)
  );

  always_ff @(posedge clk) begin
    if (rst)            overflow <= 1'b0;
    else if (cnt_carry) overflow <= 1'b1;
  end

  // R2
  open_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> gate_active);
  // R2
  tb_rollover_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_active) |-> (tb_digits == '0 && $past(tb_carry)));
  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(sel_q));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && cnt_low[CNT_DIGITS-1]) |=> (overflow && count_bcd == '0));
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_active |=> $stable(count_bcd));
endmodule

// File: tb/freq_gate_ctrl_tb_top.sv
module freq_gate_ctrl_tb_top;
  localparam int TBD = 4;
  localparam int CND = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sig_in = 1'b0;
  logic [1:0]   gate_sel = 2'd0;
  logic [CND*4-1:0] count_bcd;
  logic         overflow, gate_active, meas_done;

  int errors = 0;
  int checks = 0;
  int pat = 0;
  int pcyc = 0;
  int wd = 0;

  always #4 clk = ~clk;

  freq_gate_ctrl #(.TB_DIGITS(TBD), .CNT_DIGITS(CND)) dut_i (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_sel(gate_sel),
    .count_bcd(count_bcd), .overflow(overflow),
    .gate_active(gate_active), .meas_done(meas_done)
  );

  function automatic int bcd2int(input logic [CND*4-1:0] v);
    int r = 0;
    for (int d = CND - 1; d >= 0; d--) r = r * 10 + int'(v[d*4 +: 4]);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_gate = 0, m_done = 0, m_closed = 0, m_ovf = 0;
  int m_ph = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_sel = 0, m_lim = 10;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_gate = 0; m_done = 0; m_closed = 0; m_ovf = 0;
      m_ph = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_sel = int'(gate_sel);
      m_lim = 10 ** (m_sel + 1);
    end else begin
      if (m_s2 == 1 && m_s3 == 0 && m_gate == 1) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 10 ** CND) begin m_cnt = 0; m_ovf = 1; end
      end
      m_done = 0;
      if (m_closed == 0) begin
        if (m_gate == 0) begin
          m_gate = 1; m_ph = 0;
        end else begin
          m_ph = m_ph + 1;
          if (m_ph == m_lim) begin m_gate = 0; m_closed = 1; m_done = 1; end
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sig_in);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    chk("R6 count", bcd2int(count_bcd), m_cnt);
    chk("R7 overflow", int'(overflow), m_ovf);
    chk("R3 gate", int'(gate_active), m_gate);
    chk("R8 done", int'(meas_done), m_done);
  end

  // stimulus pattern driver
  always @(negedge clk) begin
    pcyc++;
    case (pat)
      1: sig_in <= ~sig_in;
      2: sig_in <= 1'($urandom_range(1, 0));
      3: sig_in <= 1'b1;
      4: sig_in <= ((pcyc % 6) < 3);
      default: sig_in <= 1'b0;
    endcase
  end

  task automatic run_meas(input int sel, input int p, input int sel_late, input int exp_ovf);
    int hi = 0, dn = 0, frozen, lim;
    lim = 10 ** (sel + 1);
    pat = 0;
    rst = 1'b1;
    gate_sel = 2'(sel);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 count", bcd2int(count_bcd), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 gate", int'(gate_active), 0);
    chk("R1 done", int'(meas_done), 0);
    pat = p;
    rst = 1'b0;
    @(negedge clk);
    // R2 gate opens on the first edge after reset
    chk("R2 open", int'(gate_active), 1);
    for (int c = 0; c < lim + 40; c++) begin
      if (gate_active) hi++;
      if (meas_done) dn++;
      if (c == 5) gate_sel = 2'(sel_late);
      @(negedge clk);
    end
    // R3 / R4 gate length from the latched select
    chk("R3 R4 gate length", hi, lim);
    chk("R8 single done", dn, 1);
    frozen = bcd2int(count_bcd);
    repeat (20) @(negedge clk);
    // R8 / R9 result frozen after close
    chk("R8 R9 frozen count", bcd2int(count_bcd), frozen);
    chk("R8 gate stays closed", int'(gate_active), 0);
    if (exp_ovf >= 0) chk("R7 overflow result", int'(overflow), exp_ovf);
  endtask

  initial begin
    run_meas(0, 1, 0, 0);
    run_meas(1, 2, 1, 0);
    run_meas(2, 4, 2, -1);
    // R9 held high: only one edge can exist
    run_meas(1, 3, 1, 0);
    chk("R5 R9 single edge", bcd2int(count_bcd), 1);
    // R4 select changed mid-run
    run_meas(1, 1, 3, 0);
    chk("R5 toggle count", bcd2int(count_bcd), 50);
    // R7 overflow with a 10000 cycle gate
    run_meas(3, 1, 3, 1);
    chk("R7 wrapped count", bcd2int(count_bcd), 0);
    // reset in mid-measurement, then a short run
    pat = 1; rst = 1'b1; gate_sel = 2'd2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    run_meas(0, 2, 2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule